// File: doc/BRIEF.md
# Ternary Neuron with Two-Threshold Step Output

This block computes one output of a ternary neural-network layer. Activations and weights are balanced trits (-1, 0, +1). In each accepted cycle the block takes `LANES` activation/weight pairs. It forms their products without a multiplier and reduces them in an adder tree. The first level of that tree adds pairs of trits into 3-bit signed values, and each level above adds one bit of width. The group sums are added into an accumulator over a run-time number of groups. When the last group of a neuron has been accepted, the final sum is compared with a low and a high signed threshold. The block then presents a single trit on a valid/ready output.

An upstream producer streams groups on `in_valid`/`in_ready`. The consumer takes each result on `out_valid`/`out_ready`. While a result waits, the input side is stalled, so no group can enter until the result is taken. With `LANES` = 1 the block takes one activation per cycle. Wider settings, including values that are not powers of two, let a bottleneck layer take many activations per cycle.

Top module: `tern_neuron`

## Requirements
- R1: A trit is carried on 2 bits: 00 is 0, 01 is +1, 11 is -1, and 10 is read as 0. This applies to `in_act`, `in_wgt` and `out_trit`. `out_trit` is never 10 while `out_valid` is high.
- R2: The product of an activation and a weight is 0 when either operand is 0. Otherwise it is +1 when the signs match and -1 when they differ.
- R3: An accepted group adds the sum of all `LANES` products (lane k on bits 2k+1:2k) to the running sum.
- R4: A neuron consists of `cfg_groups` accepted groups, and a value of 0 acts as 1. The running sum starts from zero for each neuron. No result appears before the last group.
- R5: The output is -1 when the final sum is strictly below `thr_lo`.
- R6: The output is +1 when the final sum is strictly above `thr_hi`. It is 0 otherwise, which includes a sum equal to either threshold.
- R7: When `thr_lo` is greater than `thr_hi`, the output is 0 whatever the sum. The thresholds are sampled in the cycle the last group is accepted.
- R8: `out_valid` rises in the cycle after the last group of a neuron is accepted. `in_ready` is low whenever `out_valid` is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_trit` hold. After an output handshake, `out_valid` is low in the next cycle.
- R10: After reset, `out_valid` is low, `in_ready` is high and the running sum is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_groups | input | GRP_W | Groups per neuron (0 acts as 1) |
| thr_lo | input | ACC_W | Signed low threshold |
| thr_hi | input | ACC_W | Signed high threshold |
| in_valid | input | 1 | Input group offered |
| in_ready | output | 1 | Input group can be taken |
| in_act | input | 2*LANES | Activation trits, lane k on bits 2k+1:2k |
| in_wgt | input | 2*LANES | Weight trits, lane k on bits 2k+1:2k |
| out_valid | output | 1 | Result trit available |
| out_ready | input | 1 | Consumer takes the result |
| out_trit | output | 2 | Result trit |

## Verification
Uniform groups (all +1 by +1, opposite signs, equal negative signs) give known sums of ±LANES. These show whether the product sign rule and the tree reach the full-scale value. Groups that mix the code 10 with valid trits give different results depending on whether 10 is taken as 0 or as a signed value. Pseudo-random multi-group neurons are run twice on the same data with thresholds set to the sum itself and to one above it, which separates strict from inclusive comparison. A 255-group run of maximal sums checks that the accumulator holds the full fan-in. A stalled result with a new group already waiting shows whether the held group is lost, merged or taken twice.

// File: rtl/tern_neuron.sv
module tern_neuron #(
  parameter int LANES = 8,
  parameter int GRP_W = 8,
  localparam int ACC_W = $clog2(LANES * (1 << GRP_W) + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GRP_W-1:0]        cfg_groups,
  input  logic signed [ACC_W-1:0] thr_lo,
  input  logic signed [ACC_W-1:0] thr_hi,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2*LANES-1:0]      in_act,
  input  logic [2*LANES-1:0]      in_wgt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [1:0]              out_trit
);

  localparam int NPAIR  = (LANES + 1) / 2;
  localparam int DEPTH  = $clog2(NPAIR);
  localparam int LEAVES = 1 << DEPTH;

  logic signed [1:0] prod [LANES];
  logic signed [2:0] pair [NPAIR];

  for (genvar k = 0; k < LANES; k++) begin : g_mul
    wire nz  = in_act[2*k] & in_wgt[2*k];
    wire neg = in_act[2*k+1] ^ in_wgt[2*k+1];
    assign prod[k] = nz ? (neg ? 2'sb11 : 2'sb01) : 2'sb00;
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    if (2*k + 1 < LANES) begin : g_two
      assign pair[k] = 3'(prod[2*k]) + 3'(prod[2*k+1]);
    end else begin : g_one
      assign pair[k] = 3'(prod[2*k]);
    end
  end

  for (genvar g = 0; g <= DEPTH; g++) begin : lv
    localparam int N = LEAVES >> g;
    localparam int W = 3 + g;
    logic signed [W-1:0] s [N];
    if (g == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_l
        if (i < NPAIR) begin : g_used
          assign s[i] = pair[i];
        end else begin : g_pad
          assign s[i] = '0;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < N; i++) begin : g_n
        assign s[i] = W'(lv[g-1].s[2*i]) + W'(lv[g-1].s[2*i+1]);
      end
    end
  end

  logic signed [ACC_W-1:0] grp_sum, acc, acc_nxt;
  logic [GRP_W-1:0]        cnt;
  logic [1:0]              step;

  assign grp_sum  = ACC_W'(lv[DEPTH].s[0]);
  assign in_ready = !out_valid;

  wire take = in_valid && in_ready;
  wire last = (cfg_groups == '0) || (cnt == cfg_groups - 1'b1);

  assign acc_nxt = ((cnt == '0) ? '0 : acc) + grp_sum;

  always_comb begin
    if (thr_lo > thr_hi)       step = 2'b00;
    else if (acc_nxt < thr_lo) step = 2'b11;
    else if (acc_nxt > thr_hi) step = 2'b01;
    else                       step = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_trit  <= 2'b00;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        acc <= acc_nxt;
        if (last) begin
          cnt       <= '0;
          out_valid <= 1'b1;
          out_trit  <= step;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

module tern_neuron_chk #(
  parameter int ACC_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [1:0]              out_trit,
  input logic signed [ACC_W-1:0] thr_lo,
  input logic signed [ACC_W-1:0] thr_hi
);

  assert_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_trit != 2'b10);

  assert_inverted_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(thr_lo > thr_hi) |-> out_trit == 2'b00);

  assert_rise_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_trit));

  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind tern_neuron tern_neuron_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_trit(out_trit),
  .thr_lo(thr_lo), .thr_hi(thr_hi)
);

// File: tb/test_tern_neuron.sv
module test_tern_neuron;
  localparam int L = 8;
  localparam int GW = 8;
  localparam int AW = $clog2(L * (1 << GW) + 1) + 1;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [GW-1:0]        cfg_groups = '0;
  logic signed [AW-1:0] thr_lo = '0, thr_hi = '0;
  logic                 in_valid = 1'b0, out_ready = 1'b0;
  logic [2*L-1:0]       in_act = '0, in_wgt = '0;
  logic                 in_ready, out_valid;
  logic [1:0]           out_trit;

  tern_neuron #(.LANES(L), .GRP_W(GW)) i_tern_neuron (
    .clk(clk), .rst_n(rst_n), .cfg_groups(cfg_groups), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_act(in_act), .in_wgt(in_wgt),
    .out_valid(out_valid), .out_ready(out_ready), .out_trit(out_trit));

  int n_run = 0, n_fail = 0;
  logic [2*L-1:0] pa [256];
  logic [2*L-1:0] pw [256];

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tv(logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
  endfunction

  function automatic logic [2*L-1:0] fill(logic [1:0] c);
    logic [2*L-1:0] r;
    for (int k = 0; k < L; k++) r[2*k +: 2] = c;
    return r;
  endfunction

  function automatic int gsum(logic [2*L-1:0] a, logic [2*L-1:0] w);
    int s = 0;
    for (int k = 0; k < L; k++) s += tv(a[2*k +: 2]) * tv(w[2*k +: 2]);
    return s;
  endfunction

  function automatic int ref_act(int s, int lo, int hi);
    if (lo > hi) return 0;
    if (s < lo) return -1;
    if (s > hi) return 1;
    return 0;
  endfunction

  task automatic push(logic [2*L-1:0] a, logic [2*L-1:0] w);
    in_act = a; in_wgt = w; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_check(int exp_t, string req);
    check(out_valid == 1'b1, "R8 valid after last group", int'(out_valid), 1);
    check(in_ready == 1'b0, "R8 input stalled", int'(in_ready), 0);
    check(out_trit != 2'b10 && tv(out_trit) == exp_t, req, tv(out_trit), exp_t);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R9 drop after handshake", int'(out_valid), 0);
  endtask

  task automatic run(int n, int lo, int hi, string req);
    int s = 0;
    int ng = (n == 0) ? 1 : n;
    cfg_groups = GW'(n);
    thr_lo = AW'(lo); thr_hi = AW'(hi);
    for (int g = 0; g < ng; g++) begin
      s += gsum(pa[g], pw[g]);
      push(pa[g], pw[g]);
      if (g < ng - 1) check(out_valid == 1'b0, "R4 no early result", int'(out_valid), 0);
    end
    pop_check(ref_act(s, lo, hi), req);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_uniform;
    pa[0] = fill(2'b01); pw[0] = fill(2'b01);
    run(1, -3, 3, "R3 R6 full positive group");
    pa[0] = fill(2'b11); pw[0] = fill(2'b01);
    run(1, -3, 3, "R2 R5 opposite signs");
    pa[0] = fill(2'b11); pw[0] = fill(2'b11);
    run(1, -3, 3, "R2 equal negative signs");
    pa[0] = 16'b11_01_00_11_01_11_01_01; pw[0] = 16'b11_11_01_00_01_01_11_01;
    run(1, 0, 0, "R2 R3 mixed lanes");
  endtask

  task automatic t_code10;
    pa[0] = {fill(2'b10)} & 16'hFF00 | (fill(2'b01) & 16'h00FF);
    pw[0] = fill(2'b01);
    run(1, 3, 3, "R1 code 10 in activation");
    pa[0] = fill(2'b01); pw[0] = fill(2'b10);
    run(1, -1, 1, "R1 code 10 in weight");
  endtask

  task automatic t_fanin;
    int s = 0;
    for (int g = 0; g < 5; g++) begin
      pa[g] = 16'($urandom); pw[g] = 16'($urandom);
      s += gsum(pa[g], pw[g]);
    end
    run(5, -2, 2, "R4 five groups");
    run(5, s - 10, s, "R6 sum equal to high threshold");
    run(5, s, s + 10, "R6 sum equal to low threshold");
    run(5, s + 1, s + 20, "R5 sum one below low threshold");
    run(5, s - 20, s - 1, "R6 sum one above high threshold");
    pa[0] = fill(2'b11); pw[0] = fill(2'b01);
    run(0, -3, 3, "R4 zero groups acts as one");
  endtask

  task automatic t_inverted;
    pa[0] = fill(2'b01); pw[0] = fill(2'b01);
    run(1, 5, -5, "R7 inverted thresholds positive sum");
    pa[0] = fill(2'b11);
    run(1, 5, -5, "R7 inverted thresholds negative sum");
  endtask

  task automatic t_stall;
    logic [1:0] held;
    cfg_groups = 1; thr_lo = -3; thr_hi = 3;
    push(fill(2'b01), fill(2'b01));
    held = out_trit;
    in_act = fill(2'b11); in_wgt = fill(2'b01); in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R9 valid held", int'(out_valid), 1);
      check(out_trit == held, "R9 trit held", tv(out_trit), tv(held));
      check(in_ready == 1'b0, "R8 stalled while pending", int'(in_ready), 0);
    end
    check(tv(out_trit) == 1, "R6 stalled result", tv(out_trit), 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R9 drop after handshake", int'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    pop_check(-1, "R4 R5 waiting group taken once");
  endtask

  task automatic t_max;
    for (int g = 0; g < 255; g++) begin pa[g] = fill(2'b01); pw[g] = fill(2'b01); end
    run(255, -1, 255 * L - 1, "R4 R6 full fan-in above");
    run(255, -1, 255 * L, "R6 full fan-in at threshold");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_uniform;
    t_code10;
    t_fanin;
    t_inverted;
    t_stall;
    t_max;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule